// File: doc/BRIEF.md
# Multiplexed Five-Digit BCD Scanner

This block presents five BCD digits one at a time on a shared 4-bit data bus. A five-line one-hot select bus marks which decade is on the data bus at that moment. A slow scan clock, which is independent of the system clock, steps the scanner one decade at a time. The scan runs from the ten-thousands decade down to the units decade and then wraps back to ten-thousands.

A scan-reset level returns the scanner to the ten-thousands decade. A first-decade inhibit flag removes the units decade from the cycle, which leaves four positions. The data bus and the select bus each have an active-high output enable. When an enable is low, its bus is released to high impedance.

Inside the block, the scan clock and the scan-reset level are synchronised to the system clock. The scanner steps on a detected rising edge of the scan clock.

Top module: `digit_scan_mux`

## Requirements
- R1: Each rising edge of `scan_clk_i` moves the scanner one position down, from ten-thousands toward units. If the edge is set up before system clock edge E0, the new position shows on the outputs after edge E2 and not before.
- R2: A step taken while units is selected goes to ten-thousands.
- R3: Exactly one `sel_o` bit is high. Bit i marks decade i (bit 0 is units, bit 4 is ten-thousands). `bcd_o` then carries `digits_i[4*i+3:4*i]`, so the lowest nibble holds the units digit.
- R4: While `scan_rst_i` is high, the scanner shows ten-thousands and scan clock edges are ignored. The reset takes effect after the third system clock edge, the same latency as R1.
- R5: While `skip_units_i` is high, the cycle is ten-thousands, thousands, hundreds, tens, and then ten-thousands again.
- R6: If `skip_units_i` goes high while units is selected, units stays shown until the next step, and that step goes to ten-thousands.
- R7: When `data_oe_i` is low, `bcd_o` is `4'bzzzz`. The select bus does not depend on `data_oe_i`.
- R8: When `sel_oe_i` is low, `sel_o` is `5'bzzzzz`. The data bus does not depend on `sel_oe_i`.
- R9: An active system reset (`rst_n` low) selects ten-thousands at once.
- R10: Holding `scan_clk_i` high for many system cycles gives only one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| digits_i | input | 20 | Five BCD digits, with units in the lowest nibble |
| scan_clk_i | input | 1 | Scan clock; the scanner steps on its rising edges |
| scan_rst_i | input | 1 | Scan reset level; high forces ten-thousands |
| skip_units_i | input | 1 | First-decade inhibit; high gives a four-position cycle |
| data_oe_i | input | 1 | Enable for the data bus |
| sel_oe_i | input | 1 | Enable for the select bus |
| bcd_o | output | 4 | Selected digit, or high impedance |
| sel_o | output | 5 | One-hot decade select, or high impedance |

## Verification
The bench checks the step latency exactly. A design with one synchroniser stage too few or too many would show the new decade one edge early or one edge late. It checks the wrap from units and the four-position cycle, where a wrong wrap bound would stop at units or drop tens. It also raises the inhibit while units is shown, which catches a design that jumps early or steps down past zero.

The bench holds the scan clock high, where level-triggered stepping would run through the decades. It sends clock edges while scan reset is high, which a design without reset priority would let through. It also drives each enable low separately, which would expose swapped or shared enables.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned NUM_DIGITS = 5;
  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/scan_position.sv
module scan_position #(
  parameter int unsigned NDIG = 5,
  localparam int unsigned IW  = $clog2(NDIG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_lvl_i,
  input  logic            hold_top_i,
  input  logic            skip_low_i,
  output logic [IW-1:0]   pos_o,
  output logic [NDIG-1:0] hot_o
);
  localparam logic [IW-1:0] TOP = IW'(NDIG-1);

  logic          lvl_q;
  logic          step;
  logic [IW-1:0] floor_idx;
  logic [IW-1:0] pos_q;

  assign step      = clk_lvl_i & ~lvl_q;
  assign floor_idx = skip_low_i ? IW'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      pos_q <= TOP;
    end else begin
      lvl_q <= clk_lvl_i;
      if (hold_top_i) pos_q <= TOP;
      else if (step) begin
        if (pos_q <= floor_idx) pos_q <= TOP;
        else pos_q <= pos_q - 1'b1;
      end
    end
  end

  assign pos_o = pos_q;
  assign hot_o = NDIG'(1) << pos_q;

  p_reset_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_top_i |=> pos_q == TOP);
  p_step_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold_top_i && pos_q > floor_idx) |=> pos_q == $past(pos_q) - 1'b1);
  p_wrap_units_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold_top_i && pos_q == '0) |=> pos_q == TOP);
  p_short_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold_top_i && skip_low_i && pos_q == IW'(1)) |=> pos_q == TOP);
  p_hold_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !hold_top_i) |=> $stable(pos_q));
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hot_o) == 1);
endmodule

// File: rtl/scan_drive.sv
module scan_drive #(
  parameter int unsigned NDIG = 5,
  parameter int unsigned DW   = 4,
  localparam int unsigned IW  = $clog2(NDIG)
) (
  input  logic [NDIG*DW-1:0] digits_i,
  input  logic [IW-1:0]      pos_i,
  input  logic [NDIG-1:0]    hot_i,
  input  logic               data_oe_i,
  input  logic               sel_oe_i,
  output logic [DW-1:0]      bcd_o,
  output logic [NDIG-1:0]    sel_o
);
  logic [DW-1:0] picked;

  assign picked = digits_i[int'(pos_i)*DW +: DW];
  assign bcd_o  = data_oe_i ? picked : {DW{1'bz}};

  genvar g;
  generate
    for (g = 0; g < NDIG; g++) begin : g_line
      assign sel_o[g] = sel_oe_i ? hot_i[g] : 1'bz;
    end
  endgenerate
endmodule

// File: rtl/digit_scan_mux.sv
module digit_scan_mux #(
  parameter int unsigned NDIG   = scan_pkg::NUM_DIGITS,
  parameter int unsigned DW     = scan_pkg::DIGIT_W,
  parameter int unsigned STAGES = scan_pkg::SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NDIG*DW-1:0] digits_i,
  input  logic               scan_clk_i,
  input  logic               scan_rst_i,
  input  logic               skip_units_i,
  input  logic               data_oe_i,
  input  logic               sel_oe_i,
  output logic [DW-1:0]      bcd_o,
  output logic [NDIG-1:0]    sel_o
);
  localparam int unsigned IW = $clog2(NDIG);

  logic          clk_lvl;
  logic          rst_lvl;
  logic [IW-1:0] pos;
  logic [NDIG-1:0] hot;

  scan_sync #(.STAGES(STAGES)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scan_clk_i), .q_o(clk_lvl));
  scan_sync #(.STAGES(STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scan_rst_i), .q_o(rst_lvl));

  scan_position #(.NDIG(NDIG)) u_pos (
    .clk(clk), .rst_n(rst_n), .clk_lvl_i(clk_lvl), .hold_top_i(rst_lvl),
    .skip_low_i(skip_units_i), .pos_o(pos), .hot_o(hot));

  scan_drive #(.NDIG(NDIG), .DW(DW)) u_drive (
    .digits_i(digits_i), .pos_i(pos), .hot_i(hot), .data_oe_i(data_oe_i),
    .sel_oe_i(sel_oe_i), .bcd_o(bcd_o), .sel_o(sel_o));

  logic [DW-1:0] hot_digit;
  always_comb begin
    hot_digit = '0;
    for (int i = 0; i < NDIG; i++)
      if (hot[i]) hot_digit = hot_digit | digits_i[i*DW +: DW];
  end

  p_bus_matches_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_i |-> bcd_o == hot_digit);
endmodule

// File: tb/sim_digit_scan_mux.sv
`timescale 1ns/1ps
module sim_digit_scan_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] digits = '0;
  logic        sclk = 1'b0, srst = 1'b0, skip = 1'b0, doe = 1'b1, soe = 1'b1;
  wire  [3:0]  bcd;
  wire  [4:0]  sel;

  int checks = 0;
  int errors = 0;
  int mpos = 4;
  logic [3:0] dg [5];

  always #4 clk = ~clk;

  digit_scan_mux u0 (
    .clk(clk), .rst_n(rst_n), .digits_i(digits), .scan_clk_i(sclk),
    .scan_rst_i(srst), .skip_units_i(skip), .data_oe_i(doe),
    .sel_oe_i(soe), .bcd_o(bcd), .sel_o(sel));

  function automatic logic [4:0] exp_sel(int p);
    return 5'b00001 << p;
  endfunction

  function automatic int next_pos(int p, logic sk);
    if (p == 0 || (sk && p == 1)) return 4;
    return p - 1;
  endfunction

  task automatic chk4(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bcd got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk5(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sel got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk4(tag, bcd, doe ? dg[mpos] : 4'bzzzz);
    chk5(tag, sel, soe ? exp_sel(mpos) : 5'bzzzzz);
  endtask

  task automatic set_digits();
    for (int i = 0; i < 5; i++) dg[i] = 4'($urandom_range(9));
    digits = {dg[4], dg[3], dg[2], dg[1], dg[0]};
  endtask

  task automatic pulse();
    @(negedge clk) sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    if (!srst) mpos = next_pos(mpos, skip);
  endtask

  initial begin
    void'($urandom(32'd1234));
    set_digits();
    repeat (3) @(negedge clk);
    check_all("R9 reset selects ten-thousands");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R9 after release");

    // R1 exact latency: drive at negedge before E0, new value after E2
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 no change after two edges");
    @(negedge clk);
    mpos = 3;
    check_all("R1 change after third edge");
    // R10: hold high, no further step
    repeat (20) @(negedge clk);
    check_all("R10 held level gives single step");
    sclk = 1'b0;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 3; k++) begin pulse(); check_all("R1 step down"); end
    pulse(); check_all("R2 wrap units to ten-thousands");

    skip = 1'b1;
    for (int k = 0; k < 4; k++) begin pulse(); check_all("R5 four-position cycle"); end
    chk5("R5 back at top", sel, 5'b10000);
    skip = 1'b0;

    for (int k = 0; k < 4; k++) pulse();
    chk5("R6 at units", sel, 5'b00001);
    @(negedge clk) skip = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R6 units held after inhibit");
    pulse(); check_all("R6 jump to ten-thousands");
    skip = 1'b0;

    pulse(); pulse();
    @(negedge clk) srst = 1'b1;
    repeat (4) @(negedge clk);
    mpos = 4;
    check_all("R4 scan reset to top");
    pulse(); check_all("R4 edges ignored during reset");
    srst = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R4 after release");

    @(negedge clk) doe = 1'b0;
    #1 check_all("R7 data bus released, sel driven");
    doe = 1'b1; soe = 1'b0;
    #1 check_all("R8 sel bus released, data driven");
    soe = 1'b1;

    for (int it = 0; it < 250; it++) begin
      case ($urandom_range(9))
        0: set_digits();
        1: skip = ~skip;
        2: doe = 1'($urandom_range(1));
        3: soe = 1'($urandom_range(1));
        4: begin
          @(negedge clk) srst = 1'b1;
          repeat (4) @(negedge clk);
          mpos = 4;
          srst = 1'b0;
          repeat (4) @(negedge clk);
        end
        default: pulse();
      endcase
      @(negedge clk);
      check_all("R3 random scan");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule